// File: doc/BRIEF.md
# External Trigger Run Controller

This block turns one asynchronous sync input into a run level for a data acquisition application. The input is resynchronized and edge-detected with a selectable polarity. A mode field then decides how the run level reacts: it can start on one edge, toggle between start and stop on each edge, follow the input as a high or low gate, or stay idle while the input is passed straight through to a per-layer sync line. One-cycle start and stop strobes mark every change of the run level.

A second path drives the sync output pin. It takes one of three sources: the resynchronized sync input, an internal timebase, or a signal supplied by an I/O layer. Configuration uses a plain write-enable bus with two word addresses: a control word at address 0 and an output select word at address 1.

Top module: `trig_run_ctrl`

## Requirements
- R1: After reset, run_o, start_o, stop_o and layer_sync_o are low. The control word resets to mode 0, rising polarity and disarmed. The output select resets to code 0.
- R2: Control word bits [2:0] hold the mode: 0 edge, 1 trigger/stop, 2 gate-high, 3 gate-low, 4 direct. Codes 5 to 7 keep the run level low. In armed edge mode, a selected edge raises run_o on the third rising clock edge after the input change, and run_o then stays high through later edges.
- R3: Control bit 3 picks the active edge: 0 for rising, 1 for falling. An edge of the other polarity has no effect in the edge and trigger/stop modes.
- R4: In armed trigger/stop mode, each selected edge toggles run_o, with the same three-clock latency as R2.
- R5: In armed gate-high mode, run_o follows the sync input three clocks later.
- R6: In armed gate-low mode, run_o follows the inverted sync input three clocks later.
- R7: In direct mode, run_o stays low and layer_sync_o follows the sync input two clocks later. In every other mode, layer_sync_o is low.
- R8: The output select word bits [1:0] choose sync_out_o. Code 0 gives the resynchronized sync input, 1 gives timebase_i, 2 gives layer_drv_i, and 3 drives it low.
- R9: start_o is high for exactly the one cycle in which run_o has just risen. stop_o is high for exactly the one cycle in which run_o has just fallen. The two are never high together.
- R10: Control bit 4 is the arm bit. While it is clear, edges and levels leave run_o low. A control write that clears it drops run_o on the write's clock edge.
- R11: A control write that changes the mode forces run_o low on the write's clock edge and leaves the arm bit as written. A later selected edge starts the run again.
- R12: Writes to addresses other than 0 and 1 change neither the run behaviour nor the output select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register word address |
| reg_wdata_i | input | DATA_W | Register write data |
| sync_in_i | input | 1 | Asynchronous external sync input |
| timebase_i | input | 1 | Internal clock source for the sync output |
| layer_drv_i | input | 1 | Layer-driven source for the sync output |
| run_o | output | 1 | Application run level |
| start_o | output | 1 | One-cycle strobe on run start |
| stop_o | output | 1 | One-cycle strobe on run stop |
| layer_sync_o | output | 1 | Pass-through of the sync input in direct mode |
| sync_out_o | output | 1 | Multiplexed sync output pin |

## Verification
The assertions assume that the register bus is driven only between clock edges and that reset is held for several cycles, so the synchronizer stages start from zero. They also assume that the control mode and arm fields change only through bus writes. For this reason, the checks on forced stops are tied to the write strobe and the write data rather than to internal timing. The stimulus changes the sync input and the bus signals only on falling clock edges. It holds each input level for at least three clocks before the run level is sampled, so every edge passes the synchronizer exactly once.

// File: rtl/trc_pkg.sv
package trc_pkg;
   localparam int MODE_W  = 3;
   localparam int POL_BIT = 3;
   localparam int ARM_BIT = 4;
   localparam int CTRL_W  = 5;
   localparam int OSEL_W  = 2;

   typedef enum logic [MODE_W-1:0] {
      MODE_EDGE     = 3'd0,
      MODE_TRIGSTOP = 3'd1,
      MODE_GATE_HI  = 3'd2,
      MODE_GATE_LO  = 3'd3,
      MODE_DIRECT   = 3'd4
   } trc_mode_e;

   typedef enum logic [OSEL_W-1:0] {
      OSEL_SYNC  = 2'd0,
      OSEL_TBASE = 2'd1,
      OSEL_LAYER = 2'd2,
      OSEL_OFF   = 2'd3
   } trc_osel_e;

   typedef struct packed {
      logic              arm;
      logic              fall;
      logic [MODE_W-1:0] mode;
   } trc_ctrl_t;
endpackage

// File: rtl/trc_sync_edge.sv
module trc_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic d_i,
   output logic lvl_o,
   output logic rise_o,
   output logic fall_o
);
   logic [STAGES-1:0] chain;
   logic              prev;

   if (STAGES < 2) begin : g_bad_stages
      $error("trc_sync_edge: STAGES must be at least 2");
   end

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) chain[0] <= 1'b0;
            else         chain[0] <= d_i;
         end
      end else begin : g_next
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) chain[s] <= 1'b0;
            else         chain[s] <= chain[s-1];
         end
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev <= 1'b0;
      else         prev <= chain[STAGES-1];
   end

   assign lvl_o  = chain[STAGES-1];
   assign rise_o = chain[STAGES-1] & ~prev;
   assign fall_o = ~chain[STAGES-1] & prev;
endmodule

// File: rtl/trc_cfg_regs.sv
module trc_cfg_regs
   import trc_pkg::*;
#(
   parameter int ADDR_W = 2,
   parameter int DATA_W = 8
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              we_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output trc_ctrl_t         ctrl_o,
   output logic [OSEL_W-1:0] osel_o,
   output logic              kill_o
);
   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
   localparam logic [ADDR_W-1:0] A_OSEL = ADDR_W'(1);

   if (DATA_W < CTRL_W) begin : g_bad_width
      $error("trc_cfg_regs: DATA_W too small for control word");
   end
   if (ADDR_W < 1) begin : g_bad_addr
      $error("trc_cfg_regs: ADDR_W must be at least 1");
   end

   if (DATA_W > CTRL_W) begin : g_spare
      logic unused_hi;
      assign unused_hi = ^wdata_i[DATA_W-1:CTRL_W];
   end

   trc_ctrl_t ctrl_q, ctrl_new;
   logic      wr_ctrl, wr_osel;

   assign ctrl_new = trc_ctrl_t'(wdata_i[CTRL_W-1:0]);
   assign wr_ctrl  = we_i && (addr_i == A_CTRL);
   assign wr_osel  = we_i && (addr_i == A_OSEL);
   assign kill_o   = wr_ctrl && (!ctrl_new.arm || (ctrl_new.mode != ctrl_q.mode));

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ctrl_q <= '0;
         osel_o <= OSEL_SYNC;
      end else begin
         if (wr_ctrl) ctrl_q <= ctrl_new;
         if (wr_osel) osel_o <= wdata_i[OSEL_W-1:0];
      end
   end

   assign ctrl_o = ctrl_q;
endmodule

// File: rtl/trc_run_fsm.sv
module trc_run_fsm
   import trc_pkg::*;
(
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [MODE_W-1:0] mode_i,
   input  logic              arm_i,
   input  logic              pol_fall_i,
   input  logic              lvl_i,
   input  logic              rise_i,
   input  logic              fall_i,
   input  logic              kill_i,
   output logic              run_o,
   output logic              start_o,
   output logic              stop_o
);
   logic run_q, run_nx, hit;

   assign hit = pol_fall_i ? fall_i : rise_i;

   always_comb begin
      run_nx = run_q;
      case (trc_mode_e'(mode_i))
         MODE_EDGE:     if (hit) run_nx = 1'b1;
         MODE_TRIGSTOP: if (hit) run_nx = ~run_q;
         MODE_GATE_HI:  run_nx = lvl_i;
         MODE_GATE_LO:  run_nx = ~lvl_i;
         default:       run_nx = 1'b0;
      endcase
      if (!arm_i || kill_i) run_nx = 1'b0;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         run_q   <= 1'b0;
         start_o <= 1'b0;
         stop_o  <= 1'b0;
      end else begin
         run_q   <= run_nx;
         start_o <= run_nx & ~run_q;
         stop_o  <= ~run_nx & run_q;
      end
   end

   assign run_o = run_q;
endmodule

// File: rtl/trc_out_mux.sv
module trc_out_mux
   import trc_pkg::*;
(
   input  logic [OSEL_W-1:0] osel_i,
   input  logic [MODE_W-1:0] mode_i,
   input  logic              lvl_i,
   input  logic              timebase_i,
   input  logic              layer_drv_i,
   output logic              sync_out_o,
   output logic              layer_sync_o
);
   always_comb begin
      case (trc_osel_e'(osel_i))
         OSEL_SYNC:  sync_out_o = lvl_i;
         OSEL_TBASE: sync_out_o = timebase_i;
         OSEL_LAYER: sync_out_o = layer_drv_i;
         default:    sync_out_o = 1'b0;
      endcase
   end

   assign layer_sync_o = (trc_mode_e'(mode_i) == MODE_DIRECT) ? lvl_i : 1'b0;
endmodule

// File: rtl/trig_run_ctrl.sv
module trig_run_ctrl
   import trc_pkg::*;
#(
   parameter int ADDR_W      = 2,
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              reg_we_i,
   input  logic [ADDR_W-1:0] reg_addr_i,
   input  logic [DATA_W-1:0] reg_wdata_i,
   input  logic              sync_in_i,
   input  logic              timebase_i,
   input  logic              layer_drv_i,
   output logic              run_o,
   output logic              start_o,
   output logic              stop_o,
   output logic              layer_sync_o,
   output logic              sync_out_o
);
   trc_ctrl_t         ctrl;
   logic [OSEL_W-1:0] osel;
   logic [MODE_W-1:0] cur_mode;
   logic              kill, lvl, rise, fall;

   assign cur_mode = ctrl.mode;

   trc_cfg_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) regs_i (
      .clk_i(clk_i), .rst_ni(rst_ni), .we_i(reg_we_i), .addr_i(reg_addr_i),
      .wdata_i(reg_wdata_i), .ctrl_o(ctrl), .osel_o(osel), .kill_o(kill)
   );

   trc_sync_edge #(.STAGES(SYNC_STAGES)) sync_i (
      .clk_i(clk_i), .rst_ni(rst_ni), .d_i(sync_in_i),
      .lvl_o(lvl), .rise_o(rise), .fall_o(fall)
   );

   trc_run_fsm fsm_i (
      .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(cur_mode), .arm_i(ctrl.arm),
      .pol_fall_i(ctrl.fall), .lvl_i(lvl), .rise_i(rise), .fall_i(fall),
      .kill_i(kill), .run_o(run_o), .start_o(start_o), .stop_o(stop_o)
   );

   trc_out_mux mux_i (
      .osel_i(osel), .mode_i(cur_mode), .lvl_i(lvl), .timebase_i(timebase_i),
      .layer_drv_i(layer_drv_i), .sync_out_o(sync_out_o), .layer_sync_o(layer_sync_o)
   );
endmodule

// File: rtl/trc_checker.sv
module trc_checker
   import trc_pkg::*;
#(
   parameter int ADDR_W = 2,
   parameter int DATA_W = 8
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              reg_we_i,
   input logic [ADDR_W-1:0] reg_addr_i,
   input logic [DATA_W-1:0] reg_wdata_i,
   input logic [MODE_W-1:0] mode_i,
   input logic              run_i,
   input logic              start_i,
   input logic              stop_i
);
   logic wr_ctrl;
   assign wr_ctrl = reg_we_i && (reg_addr_i == ADDR_W'(0));

   a_r9_start_marks_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
      start_i |-> (run_i && !$past(run_i)));
   a_r9_rise_has_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(run_i) |-> start_i);
   a_r9_stop_marks_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
      stop_i |-> (!run_i && $past(run_i)));
   a_r9_fall_has_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(run_i) |-> stop_i);
   a_r9_strobes_apart: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(start_i && stop_i));
   a_r10_disarm_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_ctrl && !reg_wdata_i[ARM_BIT]) |=> !run_i);
   a_r11_mode_change_stops: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_ctrl && (reg_wdata_i[MODE_W-1:0] != mode_i)) |=> !run_i);
   a_r7_direct_no_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_i == MODE_DIRECT && $past(mode_i) == MODE_DIRECT) |-> !run_i);
endmodule

bind trig_run_ctrl trc_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
   .clk_i(clk_i), .rst_ni(rst_ni), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
   .reg_wdata_i(reg_wdata_i), .mode_i(cur_mode), .run_i(run_o),
   .start_i(start_o), .stop_i(stop_o)
);

// File: tb/trig_run_ctrl_tb_top.sv
module trig_run_ctrl_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       we = 1'b0;
   logic [1:0] addr = '0;
   logic [7:0] wdata = '0;
   logic       sin = 1'b0, tb = 1'b0, ly = 1'b0;
   logic       run, start, stop, lsync, sout;
   int         total = 0, bad = 0;
   bit         done = 1'b0;

   always #5 clk = ~clk;

   trig_run_ctrl dut_i (
      .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
      .reg_wdata_i(wdata), .sync_in_i(sin), .timebase_i(tb), .layer_drv_i(ly),
      .run_o(run), .start_o(start), .stop_o(stop), .layer_sync_o(lsync),
      .sync_out_o(sout)
   );

   // fields: [5:4] output select, [3] sync in, [2] timebase, [1] layer drive, [0] expected
   localparam logic [5:0] VEC [0:7] = '{
      6'b00_1_0_0_1, 6'b00_0_1_1_0, 6'b01_0_1_0_1, 6'b01_1_0_1_0,
      6'b10_0_0_1_1, 6'b10_1_1_0_0, 6'b11_1_1_1_0, 6'b01_0_1_1_1
   };

   task automatic chk(input string req, input logic act, input logic exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk); we = 1'b1; addr = a; wdata = d;
      @(negedge clk); we = 1'b0;
   endtask

   task automatic drive_sync(input logic v);
      @(negedge clk); sin = v;
      repeat (3) @(negedge clk);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 run", run, 1'b0);
      chk("R1 start", start, 1'b0);
      chk("R1 stop", stop, 1'b0);
      chk("R1 layer_sync", lsync, 1'b0);
      chk("R1 sync_out", sout, 1'b0);

      // R10 unarmed edge mode ignores edges
      drive_sync(1'b1);
      chk("R10 unarmed", run, 1'b0);
      drive_sync(1'b0);

      // R2 armed rising edge start, R9 strobe
      wr(2'd0, 8'h10);
      drive_sync(1'b1);
      chk("R2 run", run, 1'b1);
      chk("R9 start", start, 1'b1);
      @(negedge clk);
      chk("R9 start one cycle", start, 1'b0);
      drive_sync(1'b0);
      chk("R2 holds", run, 1'b1);
      drive_sync(1'b1);
      chk("R2 holds again", run, 1'b1);
      chk("R9 no restart", start, 1'b0);

      // R10 disarm drops run
      wr(2'd0, 8'h00);
      chk("R10 disarm", run, 1'b0);
      chk("R9 stop", stop, 1'b1);
      drive_sync(1'b0);

      // R3, R4 trigger/stop on falling edges
      wr(2'd0, 8'h19);
      drive_sync(1'b1);
      chk("R3 wrong edge", run, 1'b0);
      drive_sync(1'b0);
      chk("R3 falling start", run, 1'b1);
      drive_sync(1'b1);
      chk("R4 hold", run, 1'b1);
      drive_sync(1'b0);
      chk("R4 stop", run, 1'b0);
      chk("R4 stop strobe", stop, 1'b1);

      // R11 mode change while running
      wr(2'd0, 8'h11);
      drive_sync(1'b1);
      chk("R4 rising start", run, 1'b1);
      wr(2'd0, 8'h10);
      chk("R11 forced stop", run, 1'b0);
      chk("R11 stop strobe", stop, 1'b1);
      drive_sync(1'b0);
      drive_sync(1'b1);
      chk("R11 rearmed", run, 1'b1);

      // R5 gate high
      wr(2'd0, 8'h12);
      chk("R11 gate switch stop", run, 1'b0);
      @(negedge clk);
      chk("R5 gate on", run, 1'b1);
      chk("R9 gate start", start, 1'b1);
      drive_sync(1'b0);
      chk("R5 gate off", run, 1'b0);
      chk("R9 gate stop", stop, 1'b1);

      // R6 gate low, R7 no layer output outside direct mode
      wr(2'd0, 8'h13);
      @(negedge clk);
      chk("R6 gate low on", run, 1'b1);
      drive_sync(1'b1);
      chk("R6 gate low off", run, 1'b0);
      chk("R7 layer quiet", lsync, 1'b0);

      // R12 writes to unused addresses ignored
      wr(2'd0, 8'h12);
      @(negedge clk);
      chk("R5 gate on again", run, 1'b1);
      wr(2'd2, 8'h01);
      chk("R12 run kept", run, 1'b1);
      @(negedge clk);
      chk("R12 run kept later", run, 1'b1);
      chk("R12 select kept", sout, 1'b1);

      // R7 direct pass-through
      wr(2'd0, 8'h04);
      @(negedge clk);
      chk("R7 run low", run, 1'b0);
      chk("R7 layer follows", lsync, 1'b1);
      sin = 1'b0;
      @(negedge clk);
      chk("R7 delay", lsync, 1'b1);
      @(negedge clk);
      chk("R7 follows low", lsync, 1'b0);

      // R8 output select table
      foreach (VEC[i]) begin
         @(negedge clk);
         sin = VEC[i][3]; tb = VEC[i][2]; ly = VEC[i][1];
         wr(2'd1, {6'd0, VEC[i][5:4]});
         repeat (3) @(negedge clk);
         chk("R8 sync_out", sout, VEC[i][0]);
      end

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule